// File: doc/BRIEF.md
# 42-bit System Timer with Match and Capture

A memory-mapped system timer for a simple 32-bit register bus. A 42-bit counter runs freely from reset. Software reads it as a 32-bit low word and a 10-bit high word. So that a low read followed by a high read gives one consistent value, each low-word read copies the upper bits into a shadow register. Every high-word read returns that shadow.

An external capture strobe copies the live count into a pair of read-only capture words. Software programs a 42-bit compare value through two match words. A write to the upper match word starts a short commit, and a ready status bit covers that commit. The comparator only ever sees a fully committed value.

When the count equals the committed value, a sticky flag is set. The interrupt line follows that flag, gated by an enable bit. A debug-run bit decides whether an asserted debug halt input freezes the counter.

Top module: `sys_timer42`

## Requirements
- R1: After reset the count starts at 0. In every cycle in which it is not halted, it increases by one, modulo 2^42.
- R2: The counter holds its value while `debug_halt` is 1 and control bit 3 (debug-run) is 0. With bit 3 set to 1, it keeps counting while `debug_halt` is 1.
- R3: A read of word 0x00 returns count bits [31:0]. The same read stores count bits [41:32] in a shadow register. A read of word 0x04 returns that shadow in bits [9:0], and bits [31:10] are zero. The shadow is 0 after reset.
- R4: When `capture_evt` is 1 at a clock edge, the count is stored. Count bits [31:0] then read at 0x08, and bits [41:32] read at bits [9:0] of 0x0C. Both words are 0 after reset.
- R5: The staged match value reads back at 0x10 (bits [31:0]) and 0x14 (bits [9:0], written from write-data bits [9:0]). After reset these read 0xFFFFFFFF and 0x3FF.
- R6: Control bit 2 (ready) is 1 when idle. A write to 0x14 while ready is 1 makes ready read 0 for exactly two cycles. After that, the full 42-bit staged value is loaded into the comparator. Writes to 0x10 or 0x14 while ready is 0 are ignored.
- R7: Control bit 0 (flag) becomes 1 in the cycle after the count equals the committed compare value. Writing 1 to bit 0 of 0x1C clears the flag. If a match and a clear fall in the same cycle, the flag stays 1.
- R8: `irq` is 1 exactly when the flag is 1 and control bit 1 (interrupt enable) is 1.
- R9: The control word at 0x1C reads 0x00000004 after reset. Bits 1 and 3 are writable, bit 2 cannot be written, and bits [31:4] read 0.
- R10: The following accesses are ignored: writes to 0x00, 0x04, 0x08, 0x0C and 0x18, and any access whose address bits [1:0] are not 00. A read of 0x18 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe (one register read per cycle) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| capture_evt | input | 1 | Capture strobe, sampled at each clock edge |
| debug_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request |

## Verification
A commit counter that is stuck or skips a state shows up on the ready bit. It reads 0 for more or fewer than two cycles after an upper match write, and a match write issued in the second busy cycle is then either accepted or lost. A bad compare register or a bad flag update shows up on `irq` and on control bit 0, one cycle late or never, once the halted count is placed just ahead of the match value and then released. Counter or shadow errors appear on the very next read of the count words, because the bench reads them in consecutive cycles.

// File: rtl/st42_pkg.sv
package st42_pkg;

    localparam int CNT_W      = 42;
    localparam int LO_W       = 32;
    localparam int HI_W       = CNT_W - LO_W;
    localparam int DATA_W     = 32;
    localparam int BUS_AW     = 5;
    localparam int WORD_AW    = BUS_AW - 2;
    localparam int COMMIT_CYC = 2;
    localparam int PEND_W     = $clog2(COMMIT_CYC + 1);

    // word index = byte address / 4
    localparam logic [WORD_AW-1:0] W_CNT_LO = 3'd0;
    localparam logic [WORD_AW-1:0] W_CNT_HI = 3'd1;
    localparam logic [WORD_AW-1:0] W_CAP_LO = 3'd2;
    localparam logic [WORD_AW-1:0] W_CAP_HI = 3'd3;
    localparam logic [WORD_AW-1:0] W_MAT_LO = 3'd4;
    localparam logic [WORD_AW-1:0] W_MAT_HI = 3'd5;
    localparam logic [WORD_AW-1:0] W_CTRL   = 3'd7;

    // control word bit positions
    localparam int CB_FLAG = 0;
    localparam int CB_ENA  = 1;
    localparam int CB_RDY  = 2;
    localparam int CB_DBG  = 3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    typedef struct packed {
        logic [LO_W-1:0]   stage_lo;
        logic [HI_W-1:0]   stage_hi;
        logic [CNT_W-1:0]  cmp;
        logic [PEND_W-1:0] pend;
    } match_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cap;
    } cap_st_t;

    typedef struct packed {
        logic            flag;
        logic            ena;
        logic            dbg;
        logic [HI_W-1:0] shadow;
    } ctl_st_t;

endpackage

// File: rtl/st42_counter.sv
module st42_counter
    import st42_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;   // wraps naturally at 2^CNT_W
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/st42_match.sv
module st42_match
    import st42_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [LO_W-1:0]   stage_lo,
    output logic [HI_W-1:0]   stage_hi,
    output logic [CNT_W-1:0]  cmp,
    output logic              ready,
    output logic              hit
);

    match_st_t st_d, st_q;

    assign ready = (st_q.pend == '0);

    always_comb begin
        st_d = st_q;
        if (wr_lo && ready) begin
            st_d.stage_lo = wdata[LO_W-1:0];
        end
        if (wr_hi && ready) begin
            st_d.stage_hi = wdata[HI_W-1:0];
            st_d.pend     = PEND_W'(COMMIT_CYC);
        end else if (!ready) begin
            st_d.pend = st_q.pend - 1'b1;
            if (st_q.pend == PEND_W'(1)) begin
                st_d.cmp = {st_q.stage_hi, st_q.stage_lo};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage_lo: '1, stage_hi: '1, cmp: '1, pend: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_lo = st_q.stage_lo;
    assign stage_hi = st_q.stage_hi;
    assign cmp      = st_q.cmp;
    assign hit      = (cnt == st_q.cmp);

endmodule

// File: rtl/st42_capture.sv
module st42_capture
    import st42_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap
);

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_evt) begin
            st_d.cap = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap = st_q.cap;

endmodule

// File: rtl/sys_timer42.sv
module sys_timer42
    import st42_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              capture_evt,
    input  logic              debug_halt,
    output logic              irq
);

    ctl_st_t st_d, st_q;

    logic [WORD_AW-1:0] word;
    logic               aligned;
    logic               wr_mat_lo, wr_mat_hi, wr_ctrl, rd_cnt_lo;
    logic               run;
    logic [CNT_W-1:0]   cnt_w, cmp_w, cap_w;
    logic [LO_W-1:0]    stg_lo_w;
    logic [HI_W-1:0]    stg_hi_w;
    logic               rdy_w, hit_w;
    logic [DATA_W-1:0]  ctrl_rd;

    assign word      = bus_addr[BUS_AW-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign wr_mat_lo = bus_wr && aligned && (word == W_MAT_LO);
    assign wr_mat_hi = bus_wr && aligned && (word == W_MAT_HI);
    assign wr_ctrl   = bus_wr && aligned && (word == W_CTRL);
    assign rd_cnt_lo = bus_rd && aligned && (word == W_CNT_LO);
    assign run       = !(debug_halt && !st_q.dbg);

    st42_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cnt   (cnt_w)
    );

    st42_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_mat_lo),
        .wr_hi    (wr_mat_hi),
        .wdata    (bus_wdata),
        .cnt      (cnt_w),
        .stage_lo (stg_lo_w),
        .stage_hi (stg_hi_w),
        .cmp      (cmp_w),
        .ready    (rdy_w),
        .hit      (hit_w)
    );

    st42_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_evt (capture_evt),
        .cnt     (cnt_w),
        .cap     (cap_w)
    );

    always_comb begin
        st_d = st_q;
        if (rd_cnt_lo) begin
            st_d.shadow = cnt_w[CNT_W-1:LO_W];
        end
        if (wr_ctrl) begin
            st_d.ena = bus_wdata[CB_ENA];
            st_d.dbg = bus_wdata[CB_DBG];
            if (bus_wdata[CB_FLAG]) begin
                st_d.flag = 1'b0;
            end
        end
        if (hit_w) begin
            st_d.flag = 1'b1;   // set has priority over clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[CB_FLAG] = st_q.flag;
        ctrl_rd[CB_ENA]  = st_q.ena;
        ctrl_rd[CB_RDY]  = rdy_w;
        ctrl_rd[CB_DBG]  = st_q.dbg;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (word)
                W_CNT_LO: bus_rdata = cnt_w[LO_W-1:0];
                W_CNT_HI: bus_rdata = DATA_W'(st_q.shadow);
                W_CAP_LO: bus_rdata = cap_w[LO_W-1:0];
                W_CAP_HI: bus_rdata = DATA_W'(cap_w[CNT_W-1:LO_W]);
                W_MAT_LO: bus_rdata = stg_lo_w;
                W_MAT_HI: bus_rdata = DATA_W'(stg_hi_w);
                W_CTRL:   bus_rdata = ctrl_rd;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = st_q.flag && st_q.ena;

endmodule

// File: rtl/st42_chk.sv
module st42_chk
    import st42_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [CNT_W-1:0]  cap,
    input logic              ready,
    input logic              flag,
    input logic              ena,
    input logic              dbg,
    input logic              halt,
    input logic              cap_evt,
    input logic              wr_hi,
    input logic              irq,
    input logic [BUS_AW-1:0] addr,
    input logic [DATA_W-1:0] rdata
);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt && !dbg) |=> cnt == $past(cnt) + 1'b1);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !dbg) |=> $stable(cnt));

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap == $past(cnt));

    // R6
    commit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && ready) |=> !ready ##1 !ready ##1 ready);

    // R6
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_hi) |=> $stable(cmp));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == cmp) |=> flag);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ena);

    // R8
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'h18) |-> rdata == '0);

endmodule

bind sys_timer42 st42_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_w),
    .cmp     (cmp_w),
    .cap     (cap_w),
    .ready   (rdy_w),
    .flag    (st_q.flag),
    .ena     (st_q.ena),
    .dbg     (st_q.dbg),
    .halt    (debug_halt),
    .cap_evt (capture_evt),
    .wr_hi   (wr_mat_hi),
    .irq     (irq),
    .addr    (bus_addr),
    .rdata   (bus_rdata)
);

// File: tb/sys_timer42_tb.sv
module sys_timer42_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        capture_evt = 1'b0;
    logic        debug_halt = 1'b1;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sys_timer42 u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .capture_evt (capture_evt),
        .debug_halt  (debug_halt),
        .irq         (irq)
    );

    // row: [74:73] op (0 read-check, 1 write), [72:68] addr, [67:36] wdata,
    //      [35:4] expected read data, [3:0] requirement number
    localparam int NV = 25;
    localparam logic [74:0] VEC [NV] = '{
        {2'd0, 5'h1C, 32'h0,        32'h00000004, 4'd9},  // R9 reset control
        {2'd0, 5'h10, 32'h0,        32'hFFFFFFFF, 4'd5},  // R5
        {2'd0, 5'h14, 32'h0,        32'h000003FF, 4'd5},  // R5
        {2'd0, 5'h08, 32'h0,        32'h00000000, 4'd4},  // R4
        {2'd0, 5'h0C, 32'h0,        32'h00000000, 4'd4},  // R4
        {2'd0, 5'h00, 32'h0,        32'h00000000, 4'd3},  // R3 halted at 0
        {2'd0, 5'h04, 32'h0,        32'h00000000, 4'd3},  // R3
        {2'd1, 5'h18, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10
        {2'd0, 5'h18, 32'h0,        32'h00000000, 4'd10}, // R10
        {2'd1, 5'h08, 32'h12345678, 32'h0,        4'd10}, // R10
        {2'd0, 5'h08, 32'h0,        32'h00000000, 4'd10}, // R10
        {2'd1, 5'h00, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10
        {2'd0, 5'h00, 32'h0,        32'h00000000, 4'd10}, // R10
        {2'd1, 5'h10, 32'hAAAA5555, 32'h0,        4'd5},  // R5
        {2'd0, 5'h10, 32'h0,        32'hAAAA5555, 4'd5},  // R5
        {2'd1, 5'h14, 32'hFFFFF123, 32'h0,        4'd6},  // R6 start commit
        {2'd0, 5'h1C, 32'h0,        32'h00000000, 4'd6},  // R6 busy cycle 1
        {2'd1, 5'h10, 32'h00000000, 32'h0,        4'd6},  // R6 busy cycle 2, dropped
        {2'd0, 5'h1C, 32'h0,        32'h00000004, 4'd6},  // R6 ready again
        {2'd0, 5'h10, 32'h0,        32'hAAAA5555, 4'd6},  // R6 write was ignored
        {2'd0, 5'h14, 32'h0,        32'h00000123, 4'd5},  // R5 10-bit mask
        {2'd1, 5'h1C, 32'h00000002, 32'h0,        4'd9},  // R9
        {2'd0, 5'h1C, 32'h0,        32'h00000006, 4'd9},  // R9
        {2'd1, 5'h1C, 32'hFFFFFFF4, 32'h0,        4'd9},  // R9 ready not writable
        {2'd0, 5'h1C, 32'h0,        32'h00000004, 4'd9}   // R9 upper bits zero
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R8 irq after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr    = (VEC[i][74:73] == 2'd1);
            bus_rd    = (VEC[i][74:73] == 2'd0);
            bus_addr  = VEC[i][72:68];
            bus_wdata = VEC[i][67:36];
            #1;
            if (VEC[i][74:73] == 2'd0)
                chk($sformatf("R%0d row %0d", VEC[i][3:0], i), bus_rdata, VEC[i][35:4]);
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;

        // R10 unaligned write to the match word is ignored
        wr(5'h11, 32'h0);
        rd(5'h10, a);
        chk("R10 unaligned write", a, 32'hAAAA5555);

        // R1 counting with debug-run set
        wr(5'h1C, 32'h8);
        rd(5'h00, a);
        rd(5'h00, b);
        chk("R1 increment", b, a + 1);
        // R2 halt once debug-run cleared
        wr(5'h1C, 32'h0);
        rd(5'h00, a);
        rd(5'h00, b);
        chk("R2 frozen", b, a);
        rd(5'h04, c);
        chk("R3 high word", c, 32'h0);

        // R4 capture
        rd(5'h00, c);
        @(negedge clk); capture_evt = 1'b1;
        @(negedge clk); capture_evt = 1'b0;
        rd(5'h08, a);
        chk("R4 capture low", a, c);
        rd(5'h0C, a);
        chk("R4 capture high", a, 32'h0);

        // R7 match three counts ahead
        rd(5'h00, c);
        wr(5'h10, c + 3);
        wr(5'h14, 32'h0);
        repeat (3) @(negedge clk);
        rd(5'h1C, a);
        chk("R7 no early flag", a, 32'h4);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 5'h1C; debug_halt = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R7 flag before match", {31'b0, bus_rdata[0]}, 32'h0);
        @(negedge clk);
        #1 chk("R7 flag after match", {31'b0, bus_rdata[0]}, 32'h1);
        chk("R8 irq disabled", {31'b0, irq}, 32'h0);
        debug_halt = 1'b1;

        wr(5'h1C, 32'h2);
        rd(5'h1C, a);
        chk("R8 control with enable", a, 32'h7);
        chk("R8 irq enabled", {31'b0, irq}, 32'h1);
        wr(5'h1C, 32'h3);
        rd(5'h1C, a);
        chk("R7 flag cleared", a, 32'h6);
        chk("R8 irq cleared", {31'b0, irq}, 32'h0);

        // R7 set wins over clear while count sits on the match value
        rd(5'h00, c);
        wr(5'h10, c);
        wr(5'h14, 32'h0);
        repeat (3) @(negedge clk);
        rd(5'h1C, a);
        chk("R7 flag on equal", a, 32'h7);
        wr(5'h1C, 32'h3);
        rd(5'h1C, a);
        chk("R7 set beats clear", a, 32'h7);
        chk("R8 irq stays", {31'b0, irq}, 32'h1);

        @(negedge clk);
        bus_rd = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule